// File: doc/BRIEF.md
# Radix-1000 Two-Minus-W Complement Unit

This block forms the correction factor `c = 2 - w` used inside a Newton-Raphson reciprocal step. The operand `w` is a fixed-point value made of `NDIG` radix-1000 digits. Each digit occupies a `DW`-bit unsigned field, and the most significant digit is the integer part, which may only be 0 or 1. The result `c` uses the same packed format.

Digit `i` sits at bits `[i*DW + DW-1 : i*DW]`. Digit 0 is the least significant fraction digit, and digit `NDIG-1` is the integer digit. A carry ripples upward through the digit cells:

- The lowest digit is `1000 - w0`.
- Each fraction digit above it is `999 - wi` plus the carry from below.
- The integer digit is `1 - w_top` plus the carry from below.

Whenever a fraction digit reaches exactly 1000, it becomes 0 and passes a carry of 1 upward. This replaces a borrow chain.

The caller presents `w` together with a one-cycle `in_valid` strobe. One clock later the result appears on `c_out`, `done` pulses, and `w_bad` reports whether the operand held an illegal digit. The result then holds until the next strobe.

Top module: `r1k_two_minus_w`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, `done` is 0, `c_out` is all zero and `w_bad` is 0.
- R2: `done` is 1 in exactly the cycles that follow a cycle with `in_valid` high. Back-to-back strobes give back-to-back `done` pulses, and there is never a pulse without a strobe.
- R3: For a legal operand, `c_out` read as a radix-1000 number equals 2 minus `w` exactly, with `NDIG-1` fraction digits and digit `NDIG-1` as the integer digit.
- R4: Result digit 0 is `1000 - w0` when `w0` is nonzero, and 0 with a carry into digit 1 when `w0` is 0.
- R5: Each fraction digit `i >= 1` is `999 - wi + carry_in`. A value of 1000 becomes 0 and carries into digit `i+1`. For legal input every fraction digit of `c_out` is at most 999.
- R6: The integer result digit is `1 - w_top + carry_in` and lies in 0..2 for legal input.
- R7: An operand of zero gives an integer digit of 2 and all fraction digits 0.
- R8: An operand of exactly 1 gives exactly 1. An operand with integer digit 1 and any nonzero fraction gives integer digit 0.
- R9: `w_bad` is set with the result when any fraction digit of `w` exceeds 999 or the integer digit exceeds 1. It is cleared by the next strobe that carries a legal operand.
- R10: In cycles without a strobe, `c_out` and `w_bad` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand strobe, one cycle per operand |
| w_in | input | NDIG*DW | Packed radix-1000 digits of w, digit 0 in the low bits |
| done | output | 1 | One-cycle pulse marking a new result |
| c_out | output | NDIG*DW | Packed radix-1000 digits of 2 - w |
| w_bad | output | 1 | Operand held a digit out of range |

## Verification
A fault in the carry chain first shows up on the strobe whose operand ends in a run of zero digits. In that case the carry must travel the whole chain, so a dropped or stuck carry leaves a digit at 1000 or miscounts the integer digit. This is visible on `c_out` in the single cycle that `done` pulses.

A fault in the result or flag registers shows up one cycle after the strobe as a missing, extra or late `done`. It can also appear in the idle cycles that follow, as a `c_out` or `w_bad` that drifts when no strobe arrived. The scoreboard compares every pulse against a model that works on whole integer values rather than digit rules.

// File: rtl/r1k_pkg.sv
package r1k_pkg;

  localparam int unsigned RADIX = 1000;

  typedef enum logic [0:0] {
    CELL_FRAC = 1'b0,
    CELL_INT  = 1'b1
  } cell_kind_e;

  // Offset that lifts RADIX to the next power of two for a dw-bit field.
  function automatic int unsigned wrap_offset(input int unsigned dw);
    return (32'd1 << dw) - RADIX;
  endfunction

endpackage

// File: rtl/r1k_rst_sync.sv
module r1k_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/r1k_digit_cell.sv
module r1k_digit_cell
  import r1k_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter cell_kind_e  KIND = CELL_FRAC
) (
  input  logic [DW-1:0] w_digit,
  input  logic          carry_in,
  output logic [DW-1:0] c_digit,
  output logic          carry_out
);

  localparam int unsigned SW   = DW + 1;
  localparam int unsigned OFFS = wrap_offset(DW);
  // (RADIX-1) + OFFS: a fraction result of exactly RADIX lands on 2**DW.
  localparam logic [SW-1:0] FRAC_BASE  = SW'(RADIX - 1 + OFFS);
  localparam logic [SW-1:0] FRAC_OFFS  = SW'(OFFS);
  localparam logic [SW-1:0] INT_BASE   = SW'(1);
  localparam logic [SW-1:0] INT_LIMIT  = SW'(2);

  generate
    if (KIND == CELL_FRAC) begin : g_frac
      logic [SW-1:0] probe;
      always_comb begin
        probe     = FRAC_BASE - {1'b0, w_digit} + {{(SW-1){1'b0}}, carry_in};
        // Top bit of the offset sum marks a result of exactly RADIX.
        carry_out = probe[SW-1];
        c_digit   = carry_out ? '0 : DW'(probe - FRAC_OFFS);
      end
    end else begin : g_int
      logic [SW-1:0] diff;
      always_comb begin
        diff      = INT_BASE - {1'b0, w_digit} + {{(SW-1){1'b0}}, carry_in};
        c_digit   = diff[DW-1:0];
        // Integer digit outside 0..2 means the operand was not legal.
        carry_out = (diff > INT_LIMIT);
      end
    end
  endgenerate

endmodule

// File: rtl/r1k_range_check.sv
module r1k_range_check
  import r1k_pkg::*;
#(
  parameter int unsigned NDIG = 6,
  parameter int unsigned DW   = 10
) (
  input  logic [NDIG*DW-1:0] w_digits,
  output logic               any_bad
);

  logic [NDIG-1:0] bad_vec;

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      if (i == NDIG - 1) begin : g_int
        assign bad_vec[i] = (w_digits[i*DW +: DW] > DW'(1));
      end else begin : g_frac
        assign bad_vec[i] = (w_digits[i*DW +: DW] > DW'(RADIX - 1));
      end
    end
  endgenerate

  assign any_bad = |bad_vec;

endmodule

// File: rtl/r1k_two_minus_w.sv
module r1k_two_minus_w
  import r1k_pkg::*;
#(
  parameter int unsigned NDIG = 6,
  parameter int unsigned DW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NDIG*DW-1:0] w_in,
  output logic               done,
  output logic [NDIG*DW-1:0] c_out,
  output logic               w_bad
);

  localparam int unsigned VW = NDIG * DW;

  logic          rst_q_n;
  logic [NDIG:0] cy;
  logic [VW-1:0] c_comb;
  logic          range_bad;

  logic [VW-1:0] c_q,    c_nxt;
  logic          bad_q,  bad_nxt;
  logic          done_q, done_nxt;

  r1k_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Digit 0 sees a carry of one: 999 - w0 + 1 = 1000 - w0.
  assign cy[0] = 1'b1;

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_cell
      r1k_digit_cell #(
        .DW   (DW),
        .KIND ((i == NDIG - 1) ? CELL_INT : CELL_FRAC)
      ) u_cell (
        .w_digit   (w_in[i*DW +: DW]),
        .carry_in  (cy[i]),
        .c_digit   (c_comb[i*DW +: DW]),
        .carry_out (cy[i+1])
      );
    end
  endgenerate

  r1k_range_check #(
    .NDIG (NDIG),
    .DW   (DW)
  ) u_range (
    .w_digits (w_in),
    .any_bad  (range_bad)
  );

  always_comb begin
    c_nxt    = c_q;
    bad_nxt  = bad_q;
    done_nxt = in_valid;
    if (in_valid) begin
      c_nxt   = c_comb;
      bad_nxt = range_bad | cy[NDIG];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      c_q    <= '0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      c_q    <= c_nxt;
      bad_q  <= bad_nxt;
      done_q <= done_nxt;
    end
  end

  assign c_out = c_q;
  assign w_bad = bad_q;
  assign done  = done_q;

  // Assertions
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(c_out) && $stable(w_bad)));
  assert_bad_int_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (w_in[VW-1 -: DW] > DW'(1))) |=> w_bad);
  assert_int_range_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && !w_bad) |-> (c_out[VW-1 -: DW] <= DW'(2)));

  generate
    for (genvar i = 0; i < NDIG - 1; i++) begin : g_chk
      assert_frac_range_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
        (done && !w_bad) |-> (c_out[i*DW +: DW] <= DW'(RADIX - 1)));
    end
  endgenerate

endmodule

// File: tb/r1k_two_minus_w_test.sv
module r1k_two_minus_w_test;

  localparam int N  = 6;
  localparam int DW = 10;
  localparam int VW = N * DW;

  typedef struct {
    logic [VW-1:0] c;
    logic          bad;
    string         tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] w_in;
  logic          done;
  logic [VW-1:0] c_out;
  logic          w_bad;

  int   errors = 0;
  int   checks = 0;
  exp_t sb_q[$];
  exp_t last_exp;
  logic finished = 1'b0;

  r1k_two_minus_w #(.NDIG(N), .DW(DW)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .w_in     (w_in),
    .done     (done),
    .c_out    (c_out),
    .w_bad    (w_bad)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [VW-1:0] pack(input int d5, input int d4, input int d3,
                                         input int d2, input int d1, input int d0);
    logic [VW-1:0] v;
    v = {DW'(d5), DW'(d4), DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    return v;
  endfunction

  // Whole-number model: c = 2 * 1000^(N-1) - w.
  function automatic exp_t model(input logic [VW-1:0] w, input string tag);
    exp_t e;
    longint unsigned val, scale, cv;
    int d;
    e.bad = 1'b0;
    val = 0;
    scale = 1;
    for (int i = N - 1; i >= 0; i--) begin
      d = int'(w[i*DW +: DW]);
      if ((i == N - 1) ? (d > 1) : (d > 999)) e.bad = 1'b1;
      val = val * 1000 + longint'(d);
    end
    for (int i = 0; i < N - 1; i++) scale = scale * 1000;
    cv = 2 * scale - val;
    e.c = '0;
    if (!e.bad) begin
      for (int i = 0; i < N; i++) begin
        e.c[i*DW +: DW] = DW'(cv % 1000);
        cv = cv / 1000;
      end
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [VW-1:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    w_in     = w;
    e = model(w, tag);
    sb_q.push_back(e);
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < k; i++) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: pop and compare on every result pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "pulse without strobe", VW'(done), '0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          last_exp = e;
          check(w_bad === e.bad, "R9", {"flag ", e.tag}, VW'(w_bad), VW'(e.bad));
          if (!e.bad) check(c_out === e.c, e.tag, "digits", c_out, e.c);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] seed;
    logic [VW-1:0] w;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    w_in     = '0;
    #1;
    check(done === 1'b0, "R1", "done in reset", VW'(done), '0);
    check(c_out === '0, "R1", "c in reset", c_out, '0);
    check(w_bad === 1'b0, "R1", "flag in reset", VW'(w_bad), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done === 1'b0 && c_out === '0 && w_bad === 1'b0, "R1", "after release",
          {c_out[VW-3:0], done, w_bad}, '0);

    put(pack(0, 0, 0, 0, 0, 0), "R7 zero");
    idle(3);
    put(pack(1, 0, 0, 0, 0, 0), "R8 one");
    idle(2);
    put(pack(1, 0, 0, 0, 0, 1), "R8 one plus ulp");
    idle(2);
    put(pack(0, 0, 0, 0, 0, 1), "R4 ulp");
    put(pack(0, 500, 0, 0, 0, 0), "R5 ripple");
    put(pack(1, 999, 999, 999, 999, 999), "R6 max");
    put(pack(0, 123, 0, 7, 0, 0), "R5 mixed zeros");
    put(pack(0, 0, 0, 0, 0, 999), "R4 top low");
    put(pack(1, 0, 0, 1, 0, 0), "R6 int zero");
    idle(4);
    // R10: outputs hold across idle cycles
    check(done === 1'b0, "R10", "done idle", VW'(done), '0);
    check(c_out === last_exp.c, "R10", "c hold", c_out, last_exp.c);

    seed = 32'h1357_9bdf;
    for (int k = 0; k < 40; k++) begin
      w = '0;
      for (int i = 0; i < N - 1; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        w[i*DW +: DW] = DW'(seed[25:10] % 1000);
        if (seed[3]) w[i*DW +: DW] = '0;
      end
      seed = seed * 32'd1664525 + 32'd1013904223;
      w[(N-1)*DW +: DW] = DW'(seed[17]);
      put(w, "R3 sweep");
      if (k % 5 == 4) idle(2);
    end
    idle(2);

    put(pack(0, 1000, 0, 0, 0, 0), "R9 frac 1000");
    idle(3);
    check(w_bad === 1'b1, "R10", "flag hold", VW'(w_bad), VW'(1));
    put(pack(2, 0, 0, 0, 0, 0), "R9 int 2");
    put(pack(0, 0, 0, 0, 0, 1023), "R9 frac 1023");
    put(pack(0, 250, 0, 0, 0, 0), "R9 cleared");
    idle(4);

    check(sb_q.size() == 0, "R2", "pending results", VW'(sb_q.size()), '0);
    finish_up();
  end

endmodule